// File: doc/BRIEF.md
# Prime-Field Opcode ALU

This block evaluates one 64-bit operation per strobe over the prime field whose modulus is 2^64 − 2^32 + 1 (0xFFFF_FFFF_0000_0001). A 4-bit tag picks the operation:

- modular addition and subtraction
- equality and unsigned less-than tests
- bitwise XOR, AND and inversion
- a left shift
- a select that tests an operand for zero

The tests use inverted truth encoding, where 0 means true and 1 means false. The select follows the same convention: a zero operand picks the "true" input.

Operands `opA`, `opB` and `opSel` are sampled on a clock edge where `inValid` is high. The result and its flags appear on the edge after that. Field operands are assumed to be already reduced below the modulus. An unknown tag produces a zero result and raises a flag, so an upstream formula engine can detect an operation it cannot lower.

The addition folds a carry out of bit 64 by adding 2^32 − 1. This works because 2^64 ≡ 2^32 − 1 modulo the prime. One conditional subtraction of the modulus then completes the reduction.

Top module: `gold_field_alu`

## Requirements
- R1: While and after reset, until the first strobe, `result` is 0 and `outValid` and `illegalOp` are 0.
- R2: `outValid` is high exactly one cycle after a cycle with `inValid` high. After a cycle with `inValid` low, `outValid` is 0 and `result` keeps its previous value whatever the other inputs do.
- R3: Tag 5 gives (A + B) mod p, for A and B below p, including A = B = p − 1.
- R4: Tag 6 gives A − B when A ≥ B, and p − B + A otherwise. For example, 0 − 1 gives p − 1.
- R5: Tag 9 gives 0 when A equals B and 1 otherwise.
- R6: Tag 10 gives 0 when A < B as unsigned numbers and 1 when A ≥ B.
- R7: Tag 11 gives A XOR B, tag 12 gives A AND B, and tag 13 gives the bitwise inverse of A, with no modular reduction.
- R8: Tag 14 gives A shifted left by B[5:0]. Bits shifted out are lost and there is no reduction, so B = 64 shifts by 0.
- R9: Tag 4 gives `opB` when A is zero and `opSel` otherwise.
- R10: Any tag other than 4, 5, 6, 9, 10, 11, 12, 13 or 14 raises `illegalOp` together with `outValid`, and forces `result` to 0. A legal tag leaves `illegalOp` low.
- R11: A result produced by tag 5 or tag 6 is always below p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: operands and tag are valid this cycle |
| opcode | input | 4 | Operation tag |
| opA | input | 64 | First operand (field element or bit vector) |
| opB | input | 64 | Second operand, shift amount, or select "true" value |
| opSel | input | 64 | Select "false" value |
| result | output | 64 | Registered result |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| illegalOp | output | 1 | The sampled tag was unknown |

## Verification
Every one of the 16 tag values is applied to every ordered pair drawn from a set of twelve operand values. The set includes 0, 1, 2, p − 2, p − 1, 2^32 − 1, 2^32, 2^63, 63, 64 and 65.

- Pairs near p − 1 separate a correct carry fold from a plain 64-bit wrap in addition.
- Cases with A < B exercise the borrow path of subtraction.
- The values 63, 64 and 65 as shift amounts show that only the low six bits count.
- Zero against non-zero first operands shows which input the select takes.
- Equal, adjacent and reversed pairs pin down the polarity of the two tests.

Between vectors the strobe is dropped while the tag and operands change, to show that the result register holds.

// File: rtl/gf_alu_pkg.sv
package gf_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    TAG_SEL = 4'd4,
    TAG_ADD = 4'd5,
    TAG_SUB = 4'd6,
    TAG_EQ  = 4'd9,
    TAG_LT  = 4'd10,
    TAG_XOR = 4'd11,
    TAG_AND = 4'd12,
    TAG_NOT = 4'd13,
    TAG_SHL = 4'd14
  } gfTag_e;

  // Strobes from the decoder to the datapath; the do* bits are one-hot or all zero.
  typedef struct packed {
    logic load;
    logic doSel;
    logic doAdd;
    logic doSub;
    logic doEq;
    logic doLt;
    logic doXor;
    logic doAnd;
    logic doNot;
    logic doShl;
  } gfCtrl_t;

endpackage

// File: rtl/gf_alu_ctrl.sv
module gf_alu_ctrl
  import gf_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opcode,
  output gfCtrl_t         ctrl,
  output logic            outValid,
  output logic            illegalOp
);

  logic anyOp;

  always_comb begin
    ctrl      = '0;
    ctrl.load = inValid;
    unique case (opcode)
      TAG_SEL: ctrl.doSel = 1'b1;
      TAG_ADD: ctrl.doAdd = 1'b1;
      TAG_SUB: ctrl.doSub = 1'b1;
      TAG_EQ:  ctrl.doEq  = 1'b1;
      TAG_LT:  ctrl.doLt  = 1'b1;
      TAG_XOR: ctrl.doXor = 1'b1;
      TAG_AND: ctrl.doAnd = 1'b1;
      TAG_NOT: ctrl.doNot = 1'b1;
      TAG_SHL: ctrl.doShl = 1'b1;
      default: ;
    endcase
  end

  assign anyOp = ctrl.doSel | ctrl.doAdd | ctrl.doSub | ctrl.doEq | ctrl.doLt |
                 ctrl.doXor | ctrl.doAnd | ctrl.doNot | ctrl.doShl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid & ~anyOp;
    end
  end

endmodule

// File: rtl/gf_alu_datapath.sv
module gf_alu_datapath
  import gf_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  gfCtrl_t           ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opSel,
  output logic [DATA_W-1:0] result
);

  localparam int HALF = DATA_W / 2;
  localparam int SH_W = $clog2(DATA_W);
  // Modulus 2^W - 2^(W/2) + 1 and the carry fold constant 2^(W/2) - 1.
  localparam logic [DATA_W-1:0] MOD_P = {{HALF{1'b1}}, {(HALF-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] FOLD  = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] sumFold, addRes, subRes, selRes, shlRes, resNext;
  logic              isEq, isLt;

  // Addition: fold the carry, then subtract the modulus once if needed.
  assign sumExt  = {1'b0, opA} + {1'b0, opB};
  assign sumFold = sumExt[DATA_W] ? (sumExt[DATA_W-1:0] + FOLD) : sumExt[DATA_W-1:0];
  assign addRes  = (sumFold >= MOD_P) ? (sumFold - MOD_P) : sumFold;

  // Subtraction: borrow wraps through the modulus.
  assign subRes  = (opA >= opB) ? (opA - opB) : (MOD_P - opB + opA);

  assign isEq    = (opA == opB);
  assign isLt    = (opA < opB);
  assign selRes  = (opA == '0) ? opB : opSel;
  assign shlRes  = opA << opB[SH_W-1:0];

  // AND-OR result mux; an unknown tag leaves every strobe low and yields zero.
  always_comb begin
    resNext = '0;
    if (ctrl.doAdd) resNext = resNext | addRes;
    if (ctrl.doSub) resNext = resNext | subRes;
    if (ctrl.doEq)  resNext = resNext | {{(DATA_W-1){1'b0}}, ~isEq};
    if (ctrl.doLt)  resNext = resNext | {{(DATA_W-1){1'b0}}, ~isLt};
    if (ctrl.doXor) resNext = resNext | (opA ^ opB);
    if (ctrl.doAnd) resNext = resNext | (opA & opB);
    if (ctrl.doNot) resNext = resNext | ~opA;
    if (ctrl.doShl) resNext = resNext | shlRes;
    if (ctrl.doSel) resNext = resNext | selRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= resNext;
  end

endmodule

// File: rtl/gold_field_alu.sv
module gold_field_alu
  import gf_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opSel,
  output logic [DATA_W-1:0] result,
  output logic              outValid,
  output logic              illegalOp
);

  gfCtrl_t ctrlBus;

  gf_alu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .opcode    (opcode),
    .ctrl      (ctrlBus),
    .outValid  (outValid),
    .illegalOp (illegalOp)
  );

  gf_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrlBus),
    .opA    (opA),
    .opB    (opB),
    .opSel  (opSel),
    .result (result)
  );

endmodule

// File: rtl/gf_alu_checker.sv
module gf_alu_checker
  import gf_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] result,
  input logic              outValid,
  input logic              illegalOp,
  input gfCtrl_t           ctrl
);

  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] MOD_P = {{HALF{1'b1}}, {(HALF-1){1'b0}}, 1'b1};

  logic [8:0] opStrobes;
  assign opStrobes = {ctrl.doSel, ctrl.doAdd, ctrl.doSub, ctrl.doEq, ctrl.doLt,
                      ctrl.doXor, ctrl.doAnd, ctrl.doNot, ctrl.doShl};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(opStrobes)); // R10

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result))); // R2

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (outValid && result == '0)); // R10

  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == TAG_ADD || opcode == TAG_SUB)) |=> (result < MOD_P)); // R11

  AST_LEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opStrobes != '0) |=> !illegalOp); // R10

endmodule

bind gold_field_alu gf_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opcode    (opcode),
  .result    (result),
  .outValid  (outValid),
  .illegalOp (illegalOp),
  .ctrl      (ctrlBus)
);

// File: tb/gold_field_alu_tb.sv
`timescale 1ns/1ps
module gold_field_alu_tb;

  localparam logic [127:0] PW = 128'hFFFF_FFFF_0000_0001;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [63:0] opA = '0, opB = '0, opSel = '0;
  logic [63:0] result;
  logic        outValid, illegalOp;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [63:0] vals [NV];

  always #4 clk = ~clk;

  gold_field_alu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .outValid(outValid), .illegalOp(illegalOp)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got cycles=%0d expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic string tagOf(logic [3:0] op);
    case (op)
      4'd4:  return "R9";
      4'd5:  return "R3";
      4'd6:  return "R4";
      4'd9:  return "R5";
      4'd10: return "R6";
      4'd11, 4'd12, 4'd13: return "R7";
      4'd14: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic isLegal(logic [3:0] op);
    return op == 4 || op == 5 || op == 6 || (op >= 9 && op <= 14);
  endfunction

  function automatic logic [63:0] refOut(logic [3:0] op, logic [63:0] a, logic [63:0] b,
                                         logic [63:0] c);
    logic [127:0] wa, wb;
    wa = {64'd0, a};
    wb = {64'd0, b};
    case (op)
      4'd4:  return (a == 64'd0) ? b : c;
      4'd5:  return 64'((wa + wb) % PW);
      4'd6:  return 64'((wa + PW - wb) % PW);
      4'd9:  return (a == b) ? 64'd0 : 64'd1;
      4'd10: return (a < b) ? 64'd0 : 64'd1;
      4'd11: return a ^ b;
      4'd12: return a & b;
      4'd13: return ~a;
      4'd14: return 64'((wa * (128'd1 << b[5:0])) & {64'd0, {64{1'b1}}});
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(string tag, logic ok, logic [63:0] gotR, logic gotV, logic gotI,
                       logic [63:0] expR, logic expV, logic expI);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: got result=%h valid=%b illegal=%b, expected result=%h valid=%b illegal=%b",
               tag, gotR, gotV, gotI, expR, expV, expI);
    end
  endtask

  initial begin
    vals[0]  = 64'd0;
    vals[1]  = 64'd1;
    vals[2]  = 64'd2;
    vals[3]  = 64'd63;
    vals[4]  = 64'd64;
    vals[5]  = 64'd65;
    vals[6]  = 64'h0000_0000_FFFF_FFFF;
    vals[7]  = 64'h0000_0001_0000_0000;
    vals[8]  = 64'h8000_0000_0000_0000;
    vals[9]  = 64'hFFFF_FFFE_FFFF_FFFF;  // p - 2
    vals[10] = 64'hFFFF_FFFF_0000_0000;  // p - 1
    vals[11] = 64'hDEAD_BEEF_1234_5678;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", result == 0 && !outValid && !illegalOp, result, outValid, illegalOp, 64'd0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", result == 0 && !outValid && !illegalOp, result, outValid, illegalOp, 64'd0, 1'b0, 1'b0);

    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < NV; i++) begin
        for (int j = 0; j < NV; j++) begin
          logic [63:0] expR, heldR;
          logic        expI;
          opcode  = 4'(op);
          opA     = vals[i];
          opB     = vals[j];
          opSel   = vals[(i + j + 5) % NV];
          inValid = 1'b1;
          expR = refOut(opcode, opA, opB, opSel);
          expI = !isLegal(opcode);
          @(negedge clk);
          check(tagOf(4'(op)), result == expR && outValid && illegalOp == expI,
                result, outValid, illegalOp, expR, 1'b1, expI);
          if (op == 5 || op == 6)  // R11
            check("R11", result < 64'(PW), result, outValid, illegalOp, expR, 1'b1, 1'b0);
          // R2: drop the strobe and disturb the inputs; result must hold
          heldR   = result;
          inValid = 1'b0;
          opcode  = 4'(op + 3);
          opA     = ~opA;
          opB     = opB + 64'd7;
          @(negedge clk);
          check("R2", result == heldR && !outValid && !illegalOp,
                result, outValid, illegalOp, heldR, 1'b0, 1'b0);
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule